// File: doc/BRIEF.md
# Two-Phase Transition Handshake Link

This block carries one data word at a time from a sender clock domain to a receiver clock domain. It uses transition signalling: each flip of the request line or the acknowledge line stands for one event, whatever its level. Neither line returns to zero between transfers. A transfer is one request flip followed by one acknowledge flip. The first transfer raises both lines and the second lowers them, and the pattern repeats from there.

On the sender side, local logic gives a single-cycle start with a data word. The sender flips the request line and holds the word on a bundled bus until the matching acknowledge flip comes back. It then gives a single-cycle done. On the receiver side, a flip of the synchronized request raises a single-cycle valid together with the captured word. Local logic answers with a single-cycle completion, which flips the acknowledge line.

Each side keeps a phase bit, the last synchronized level it has seen of the other side's line, and compares the incoming line against it to spot new events. Both crossing lines pass through a chain of flip-flops before use. The reset of each domain is asserted asynchronously and released in step with that domain's clock.

Top module: `tpl_link`

## Requirements
- R1: After reset, link_req, link_ack, m_busy, m_done and s_req_valid are all 0.
- R2: A start taken while m_busy is 0 flips link_req at that m_clk edge and loads m_data onto link_data. m_busy reads 1 from that edge on.
- R3: A start raised while m_busy is 1 is ignored: link_req and link_data keep their values.
- R4: link_data holds the accepted word for as long as m_busy is 1.
- R5: Each link_req flip, once it has passed the SYNC_STAGES-flop synchronizer in the s_clk domain, gives exactly one s_req_valid pulse one s_clk cycle wide. s_data shows the carried word in that cycle.
- R6: An s_done pulse after s_req_valid flips link_ack once. An s_done with no request pending leaves link_ack unchanged and produces no m_done.
- R7: m_done is a one-cycle pulse. It is raised when the synchronized acknowledge comes to equal link_req, and m_busy is 0 in the same cycle.
- R8: Transfers alternate in sense. Odd-numbered transfers drive link_req and then link_ack from 0 to 1, and even-numbered ones drive them from 1 to 0, with no return to zero in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | Sender-domain clock |
| m_rst_n | input | 1 | Sender-domain reset, active low, asynchronous assert |
| m_start | input | 1 | Start request with m_data, sampled when m_busy is 0 |
| m_data | input | DATA_W | Word to carry |
| m_busy | output | 1 | A transfer is outstanding |
| m_done | output | 1 | One-cycle pulse when the acknowledge flip has arrived |
| s_clk | input | 1 | Receiver-domain clock |
| s_rst_n | input | 1 | Receiver-domain reset, active low, asynchronous assert |
| s_req_valid | output | 1 | One-cycle pulse for a newly arrived request |
| s_data | output | DATA_W | Captured word, valid with s_req_valid |
| s_done | input | 1 | Completion pulse from receiver logic |
| link_req | output | 1 | Request line driven by the sender |
| link_ack | output | 1 | Acknowledge line driven by the receiver |
| link_data | output | DATA_W | Bundled word held by the sender |

## Verification
The bench runs four transfers in a row and checks that both lines rise on the odd ones and fall on the even ones. A design that returned to zero, or that detected levels instead of flips, would stall or run extra transfers. A second start is pushed into the cycle right after an accepted one; a design that failed to refuse it would flip the request back and change the word while the receiver is reading it. A completion is also given with nothing pending, which would flip the acknowledge line in a design that did not gate it on its phase bit. Single-cycle width and exact counts of valid and done pulses catch edge detectors that fire on a level or fire twice.

// File: rtl/tpl_pkg.sv
package tpl_pkg;
  localparam int unsigned TPL_DATA_W      = 16;
  localparam int unsigned TPL_SYNC_STAGES = 2;

  // Returns 1 when a line's level disagrees with the recorded phase, i.e. an
  // unconsumed event is present on that line.
  function automatic logic phase_differs(input logic line, input logic phase);
    return line ^ phase;
  endfunction
endpackage

// File: rtl/tpl_sync.sv
module tpl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("tpl_sync needs at least two stages");
    end
  endgenerate

  always_comb begin
    chain_d = {chain_q[LAST-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[LAST];
endmodule

// File: rtl/tpl_master.sv
module tpl_master #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ack_sync,
  output logic              busy,
  output logic              done,
  output logic              req,
  output logic [DATA_W-1:0] data_out
);
  import tpl_pkg::*;

  logic              req_q, req_d;
  logic              ack_seen_q, ack_seen_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              outstanding;
  logic              accept;

  always_comb begin
    outstanding = phase_differs(ack_sync, req_q);
    accept      = start & ~outstanding;
    req_d       = req_q ^ accept;
    word_d      = data_in;
    ack_seen_d  = ack_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      ack_seen_q <= 1'b0;
      word_q     <= '0;
    end else begin
      req_q      <= req_d;
      ack_seen_q <= ack_seen_d;
      if (accept) word_q <= word_d;
    end
  end

  assign busy     = outstanding;
  assign done     = phase_differs(ack_sync, ack_seen_q);
  assign req      = req_q;
  assign data_out = word_q;
endmodule

// File: rtl/tpl_slave.sv
module tpl_slave #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_sync,
  input  logic [DATA_W-1:0] data_in,
  input  logic              done_in,
  output logic              valid,
  output logic [DATA_W-1:0] data_out,
  output logic              ack
);
  import tpl_pkg::*;

  logic              req_seen_q, req_seen_d;
  logic              ack_q, ack_d;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              new_evt;
  logic              pending;

  always_comb begin
    new_evt    = phase_differs(req_sync, req_seen_q);
    pending    = phase_differs(req_seen_q, ack_q);
    req_seen_d = req_sync;
    valid_d    = new_evt;
    word_d     = data_in;
    ack_d      = ack_q ^ (pending & done_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen_q <= 1'b0;
      ack_q      <= 1'b0;
      valid_q    <= 1'b0;
      word_q     <= '0;
    end else begin
      req_seen_q <= req_seen_d;
      ack_q      <= ack_d;
      valid_q    <= valid_d;
      if (new_evt) word_q <= word_d;
    end
  end

  assign valid    = valid_q;
  assign data_out = word_q;
  assign ack      = ack_q;
endmodule

// File: rtl/tpl_link.sv
module tpl_link #(
  parameter int unsigned DATA_W      = tpl_pkg::TPL_DATA_W,
  parameter int unsigned SYNC_STAGES = tpl_pkg::TPL_SYNC_STAGES
) (
  input  logic              m_clk,
  input  logic              m_rst_n,
  input  logic              m_start,
  input  logic [DATA_W-1:0] m_data,
  output logic              m_busy,
  output logic              m_done,
  input  logic              s_clk,
  input  logic              s_rst_n,
  output logic              s_req_valid,
  output logic [DATA_W-1:0] s_data,
  input  logic              s_done,
  output logic              link_req,
  output logic              link_ack,
  output logic [DATA_W-1:0] link_data
);
  logic m_rst_sync_n;
  logic s_rst_sync_n;
  logic ack_in_m;
  logic req_in_s;

  // Reset release aligned to each domain's clock.
  tpl_sync #(.STAGES(2)) u_m_rst (
    .clk(m_clk), .rst_n(m_rst_n), .d(1'b1), .q(m_rst_sync_n)
  );
  tpl_sync #(.STAGES(2)) u_s_rst (
    .clk(s_clk), .rst_n(s_rst_n), .d(1'b1), .q(s_rst_sync_n)
  );

  // Line crossings.
  tpl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(m_clk), .rst_n(m_rst_sync_n), .d(link_ack), .q(ack_in_m)
  );
  tpl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(s_clk), .rst_n(s_rst_sync_n), .d(link_req), .q(req_in_s)
  );

  tpl_master #(.DATA_W(DATA_W)) u_master (
    .clk      (m_clk),
    .rst_n    (m_rst_sync_n),
    .start    (m_start),
    .data_in  (m_data),
    .ack_sync (ack_in_m),
    .busy     (m_busy),
    .done     (m_done),
    .req      (link_req),
    .data_out (link_data)
  );

  tpl_slave #(.DATA_W(DATA_W)) u_slave (
    .clk      (s_clk),
    .rst_n    (s_rst_sync_n),
    .req_sync (req_in_s),
    .data_in  (link_data),
    .done_in  (s_done),
    .valid    (s_req_valid),
    .data_out (s_data),
    .ack      (link_ack)
  );
endmodule

// File: rtl/tpl_link_chk.sv
module tpl_link_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              m_clk,
  input logic              m_rst_n,
  input logic              m_start,
  input logic              m_busy,
  input logic              m_done,
  input logic              s_clk,
  input logic              s_rst_n,
  input logic              s_req_valid,
  input logic              s_done,
  input logic              link_req,
  input logic              link_ack,
  input logic [DATA_W-1:0] link_data
);
  // R2
  req_moves_on_accept_chk: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    !$stable(link_req) |-> $past(m_start && !m_busy));

  // R3
  busy_start_ignored_chk: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    (m_start && m_busy) |=> $stable(link_req));

  // R4
  word_held_chk: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    (m_busy && $past(m_busy)) |-> $stable(link_data));

  // R7
  done_after_busy_chk: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    m_done |-> ($past(m_busy) && !m_busy));

  // R7
  done_single_chk: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    m_done |=> !m_done);

  // R6
  ack_moves_on_done_chk: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    !$stable(link_ack) |-> $past(s_done));

  // R5
  valid_single_chk: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    s_req_valid |=> !s_req_valid);
endmodule

bind tpl_link tpl_link_chk #(.DATA_W(DATA_W)) u_chk (
  .m_clk       (m_clk),
  .m_rst_n     (m_rst_n),
  .m_start     (m_start),
  .m_busy      (m_busy),
  .m_done      (m_done),
  .s_clk       (s_clk),
  .s_rst_n     (s_rst_n),
  .s_req_valid (s_req_valid),
  .s_done      (s_done),
  .link_req    (link_req),
  .link_ack    (link_ack),
  .link_data   (link_data)
);

// File: tb/tpl_link_bench.sv
module tpl_link_bench;
  localparam int unsigned DATA_W     = 16;
  localparam time         CLK_PERIOD = 10;
  localparam time         S_PERIOD   = 14;
  localparam int unsigned WAIT_LIM   = 60;

  logic              m_clk = 1'b0;
  logic              s_clk = 1'b0;
  logic              m_rst_n, s_rst_n;
  logic              m_start, s_done;
  logic [DATA_W-1:0] m_data;
  logic              m_busy, m_done, s_req_valid, link_req, link_ack;
  logic [DATA_W-1:0] s_data, link_data;

  int n_chk  = 0;
  int n_fail = 0;
  int valid_cnt = 0;
  int done_cnt  = 0;
  logic lvl = 1'b0;

  always #(CLK_PERIOD/2) m_clk = ~m_clk;
  always #(S_PERIOD/2)   s_clk = ~s_clk;

  tpl_link #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_tpl_link (
    .m_clk(m_clk), .m_rst_n(m_rst_n), .m_start(m_start), .m_data(m_data),
    .m_busy(m_busy), .m_done(m_done),
    .s_clk(s_clk), .s_rst_n(s_rst_n), .s_req_valid(s_req_valid),
    .s_data(s_data), .s_done(s_done),
    .link_req(link_req), .link_ack(link_ack), .link_data(link_data)
  );

  always @(negedge s_clk) if (s_rst_n && s_req_valid) valid_cnt++;
  always @(negedge m_clk) if (m_rst_n && m_done) done_cnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    m_rst_n = 1'b0; s_rst_n = 1'b0; m_start = 1'b0; s_done = 1'b0; m_data = '0;
    repeat (4) @(negedge m_clk);
    m_rst_n = 1'b1; s_rst_n = 1'b1;
    repeat (6) @(negedge s_clk);
    @(negedge m_clk);
    chk(link_req == 1'b0, "R1 link_req", link_req, 0);
    chk(link_ack == 1'b0, "R1 link_ack", link_ack, 0);
    chk(m_busy == 1'b0,   "R1 m_busy", m_busy, 0);
    chk(m_done == 1'b0,   "R1 m_done", m_done, 0);
    chk(s_req_valid == 1'b0, "R1 s_req_valid", s_req_valid, 0);
  endtask

  // One full transfer; poke adds a refused start right after acceptance.
  task automatic xfer(input logic [DATA_W-1:0] word, input bit poke);
    int   v0, d0;
    bit   got;
    logic exp_lvl;
    exp_lvl = ~lvl;
    v0 = valid_cnt; d0 = done_cnt;
    @(negedge m_clk); m_start = 1'b1; m_data = word;
    @(negedge m_clk); m_start = 1'b0;
    chk(m_busy == 1'b1, "R2 busy after start", m_busy, 1);
    chk(link_req == exp_lvl, "R8 req sense", link_req, exp_lvl);
    chk(link_data == word, "R2 word loaded", link_data, word);
    if (poke) begin
      m_start = 1'b1; m_data = ~word;
      @(negedge m_clk); m_start = 1'b0;
      chk(link_req == exp_lvl, "R3 req kept", link_req, exp_lvl);
      chk(link_data == word, "R3 word kept", link_data, word);
    end
    got = 1'b0;
    for (int i = 0; i < WAIT_LIM && !got; i++) begin
      @(negedge s_clk);
      if (s_req_valid) got = 1'b1;
    end
    chk(got, "R5 valid seen", got, 1);
    chk(s_data == word, "R5 s_data", s_data, word);
    @(negedge s_clk);
    chk(s_req_valid == 1'b0, "R5 valid width", s_req_valid, 0);
    chk(link_data == word, "R4 word held", link_data, word);
    chk(link_ack == lvl, "R6 ack waits", link_ack, lvl);
    s_done = 1'b1;
    @(negedge s_clk); s_done = 1'b0;
    chk(link_ack == exp_lvl, "R8 ack sense", link_ack, exp_lvl);
    got = 1'b0;
    for (int i = 0; i < WAIT_LIM && !got; i++) begin
      @(negedge m_clk);
      if (m_done) got = 1'b1;
    end
    chk(got, "R7 done seen", got, 1);
    chk(m_busy == 1'b0, "R7 busy low with done", m_busy, 0);
    @(negedge m_clk);
    chk(m_done == 1'b0, "R7 done width", m_done, 0);
    repeat (8) @(negedge s_clk);
    chk(valid_cnt == v0 + 1, "R5 one valid per flip", valid_cnt, v0 + 1);
    chk(done_cnt == d0 + 1, "R7 one done per transfer", done_cnt, d0 + 1);
    lvl = exp_lvl;
  endtask

  task automatic t_alternate();
    xfer(16'h1234, 1'b0);
    xfer(16'hA5C3, 1'b0);
    xfer(16'h0001, 1'b0);
    xfer(16'hFFFF, 1'b0);
    chk(link_req == 1'b0, "R8 both low after four", link_req, 0);
  endtask

  task automatic t_refuse();
    xfer(16'h5A5A, 1'b1);
  endtask

  task automatic t_idle_done();
    int d0;
    logic a0;
    d0 = done_cnt; a0 = link_ack;
    @(negedge s_clk); s_done = 1'b1;
    repeat (3) @(negedge s_clk);
    s_done = 1'b0;
    repeat (10) @(negedge s_clk);
    chk(link_ack == a0, "R6 idle done ignored", link_ack, a0);
    chk(done_cnt == d0, "R6 no m_done", done_cnt, d0);
    chk(m_busy == 1'b0, "R6 still idle", m_busy, 0);
  endtask

  initial begin
    t_reset();
    t_idle_done();
    t_alternate();
    t_refuse();
    t_idle_done();
    xfer(16'h0F0F, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule